// File: doc/BRIEF.md
# Nibble RAM with status characters

This block is a 4-bit data memory for a small processor that works on nibbles. The processor never sends a full address with each data access. It first sends a set-address command with an 8-bit value, and the block holds that value in its own address register. After that, data commands work on the location held there. The register is kept across any number of data commands.

The block has 4 registers. Each register holds 16 main characters that the address selects and 4 status characters. A status character is selected by a fixed index carried in the command, together with the register part of the held address. The block also drives a 4-bit output port, which has no read path.

All commands, including set-address, are ignored unless the bank-enable input is high. A system can decode bank-select bits into several such enables, one per device. Read results come out one clock after the command, on a data output that stays at zero otherwise.

Top module: `nibble_ram`

## Requirements
- R1: After reset `rdata` is 0, `rvalid` is 0, `port_out` is 0000 and the held address is 0. A data command sent before any set-address command works on register 0, character 0.
- R2: An accepted set-address command (`cmd`=1) latches `addr_in[5:0]` and ignores `addr_in[7:6]`. Bits 5:4 select the register and bits 3:0 select the character.
- R3: An accepted write-character command (`cmd`=3) stores `wdata` at the addressed main character. An accepted read-character command (`cmd`=2) returns that nibble on `rdata` with `rvalid` high in the cycle after the command edge.
- R4: An accepted arithmetic-operand read (`cmd`=7) returns the addressed main character exactly as `cmd`=2 does.
- R5: Write-status (`cmd`=5) and read-status (`cmd`=4) access status nibble `cmd_idx` (0..3) of the register chosen by address bits 5:4. Status nibbles are separate from the main characters.
- R6: An accepted port-write command (`cmd`=6) loads `wdata` into `port_out` at the command edge. No other command changes `port_out`.
- R7: While `bank_en` is low, a command changes neither storage, the held address nor the port, and no read result appears (`rvalid` stays 0).
- R8: The held address keeps its value across any number of data commands until the next accepted set-address command.
- R9: `rdata` is 0 in every cycle in which `rvalid` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bank_en | input | 1 | Device enable from the bank decoder |
| cmd_valid | input | 1 | A command is present this cycle |
| cmd | input | 3 | Command code: 0 idle, 1 set address, 2 read char, 3 write char, 4 read status, 5 write status, 6 write port, 7 arithmetic read |
| cmd_idx | input | 2 | Fixed status index for commands 4 and 5 |
| addr_in | input | 8 | Address value for command 1 |
| wdata | input | 4 | Write data for commands 3, 5 and 6 |
| rdata | output | 4 | Registered read data |
| rvalid | output | 1 | rdata holds a read result |
| port_out | output | 4 | Output-only port |

## Verification
The assertions assume at most one command per cycle. They also assume that `cmd_valid`, `cmd`, `bank_en` and the data inputs are steady around the clock edge, and that the status index is in range whenever a status command is sent. The scoreboard driver changes inputs only on the falling edge. It sends one command per task call, and it sends no read from a location before that location has been written, because storage contents after reset are undefined. Disabled commands use deliberately different data and addresses, so that any leak would show up in a later read or on the port.

// File: rtl/nram_pkg.sv
package nram_pkg;

  typedef enum logic [2:0] {
    CMD_IDLE    = 3'd0,
    CMD_SETADDR = 3'd1,
    CMD_RDCHAR  = 3'd2,
    CMD_WRCHAR  = 3'd3,
    CMD_RDSTAT  = 3'd4,
    CMD_WRSTAT  = 3'd5,
    CMD_WRPORT  = 3'd6,
    CMD_RDARITH = 3'd7
  } nram_cmd_e;

  // Main character reads: the plain read and the arithmetic operand read.
  function automatic logic reads_main(nram_cmd_e c);
    return (c == CMD_RDCHAR) || (c == CMD_RDARITH);
  endfunction

  // Flat main-array index from register and character selects.
  function automatic int unsigned main_slot(int unsigned rsel, int unsigned csel,
                                            int unsigned nchar);
    return rsel * nchar + csel;
  endfunction

endpackage

// File: rtl/nram_addr_reg.sv
module nram_addr_reg #(
  parameter int IN_W = 8,
  parameter int AW   = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic [IN_W-1:0] din,
  output logic [AW-1:0]   q
);
  // Only the low AW bits are kept; the upper bits of the command value are dropped.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= '0;
    else if (load) q <= din[AW-1:0];
  end
endmodule

// File: rtl/nram_store.sv
module nram_store
  import nram_pkg::*;
#(
  parameter int DW    = 4,
  parameter int NREG  = 4,
  parameter int NCHAR = 16,
  parameter int NSTAT = 4,
  localparam int RSEL_W = $clog2(NREG),
  localparam int CSEL_W = $clog2(NCHAR),
  localparam int SSEL_W = $clog2(NSTAT)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [RSEL_W-1:0] rsel,
  input  logic [CSEL_W-1:0] csel,
  input  logic [SSEL_W-1:0] ssel,
  input  logic              wr_main,
  input  logic              wr_stat,
  input  logic              rd_main,
  input  logic              rd_stat,
  input  logic [DW-1:0]     wdata,
  output logic [DW-1:0]     rdata,
  output logic              rvalid
);
  localparam int NMAIN = NREG * NCHAR;

  logic [DW-1:0] main_mem [NMAIN];
  logic [DW-1:0] stat_rd_per_reg [NREG];
  logic [DW-1:0] main_rd;
  logic [DW-1:0] rd_next;

  // Main characters: one flat array, no reset (contents undefined after reset).
  always_ff @(posedge clk) begin
    if (wr_main) main_mem[main_slot(int'(rsel), int'(csel), NCHAR)] <= wdata;
  end
  assign main_rd = main_mem[main_slot(int'(rsel), int'(csel), NCHAR)];

  // Status characters: one small bank per register.
  for (genvar r = 0; r < NREG; r++) begin : g_stat
    logic [DW-1:0] bank [NSTAT];
    always_ff @(posedge clk) begin
      if (wr_stat && rsel == RSEL_W'(r)) bank[ssel] <= wdata;
    end
    assign stat_rd_per_reg[r] = bank[ssel];
  end

  always_comb begin
    rd_next = '0;
    if (rd_main)      rd_next = main_rd;
    else if (rd_stat) rd_next = stat_rd_per_reg[rsel];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata  <= '0;
      rvalid <= 1'b0;
    end else begin
      rdata  <= rd_next;
      rvalid <= rd_main | rd_stat;
    end
  end
endmodule

// File: rtl/nram_port.sv
module nram_port #(
  parameter int DW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= '0;
    else if (load) q <= din;
  end
endmodule

// File: rtl/nibble_ram.sv
module nibble_ram
  import nram_pkg::*;
#(
  parameter int DW    = 4,
  parameter int NREG  = 4,
  parameter int NCHAR = 16,
  parameter int NSTAT = 4,
  parameter int IN_W  = 8,
  localparam int RSEL_W = $clog2(NREG),
  localparam int CSEL_W = $clog2(NCHAR),
  localparam int SSEL_W = $clog2(NSTAT),
  localparam int AW     = RSEL_W + CSEL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bank_en,
  input  logic              cmd_valid,
  input  logic [2:0]        cmd,
  input  logic [SSEL_W-1:0] cmd_idx,
  input  logic [IN_W-1:0]   addr_in,
  input  logic [DW-1:0]     wdata,
  output logic [DW-1:0]     rdata,
  output logic              rvalid,
  output logic [DW-1:0]     port_out
);
  nram_cmd_e   op;
  logic        take;
  logic        src_acc, wrm_acc, rdm_acc, wrs_acc, rds_acc, wmp_acc, rd_acc;
  logic [AW-1:0] addr_q;

  assign op      = nram_cmd_e'(cmd);
  assign take    = cmd_valid & bank_en;
  assign src_acc = take && (op == CMD_SETADDR);
  assign wrm_acc = take && (op == CMD_WRCHAR);
  assign rdm_acc = take && reads_main(op);
  assign wrs_acc = take && (op == CMD_WRSTAT);
  assign rds_acc = take && (op == CMD_RDSTAT);
  assign wmp_acc = take && (op == CMD_WRPORT);
  assign rd_acc  = rdm_acc | rds_acc;

  nram_addr_reg #(.IN_W(IN_W), .AW(AW)) addr_i (
    .clk(clk), .rst_n(rst_n), .load(src_acc), .din(addr_in), .q(addr_q)
  );

  nram_store #(.DW(DW), .NREG(NREG), .NCHAR(NCHAR), .NSTAT(NSTAT)) store_i (
    .clk(clk), .rst_n(rst_n),
    .rsel(addr_q[AW-1 -: RSEL_W]), .csel(addr_q[CSEL_W-1:0]), .ssel(cmd_idx),
    .wr_main(wrm_acc), .wr_stat(wrs_acc), .rd_main(rdm_acc), .rd_stat(rds_acc),
    .wdata(wdata), .rdata(rdata), .rvalid(rvalid)
  );

  nram_port #(.DW(DW)) port_i (
    .clk(clk), .rst_n(rst_n), .load(wmp_acc), .din(wdata), .q(port_out)
  );
endmodule

// File: rtl/nram_chk.sv
module nram_chk #(
  parameter int DW   = 4,
  parameter int AW   = 6,
  parameter int IN_W = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            bank_en,
  input logic [IN_W-1:0] addr_in,
  input logic [DW-1:0]   wdata,
  input logic            rd_acc,
  input logic            src_acc,
  input logic            wmp_acc,
  input logic [AW-1:0]   addr_q,
  input logic [DW-1:0]   rdata,
  input logic            rvalid,
  input logic [DW-1:0]   port_out
);
  // R3
  rd_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_acc |=> rvalid);
  // R7
  no_spurious_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_acc |=> !rvalid);
  // R9
  rdata_idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rvalid |-> (rdata == '0));
  // R6
  port_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wmp_acc |=> $stable(port_out));
  // R6
  port_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wmp_acc |=> (port_out == $past(wdata)));
  // R8
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !src_acc |=> $stable(addr_q));
  // R2
  addr_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    src_acc |=> (addr_q == $past(addr_in[AW-1:0])));
  // R7
  bank_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bank_en |=> ($stable(addr_q) && $stable(port_out) && !rvalid));
endmodule

bind nibble_ram nram_chk #(.DW(DW), .AW(AW), .IN_W(IN_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .bank_en(bank_en), .addr_in(addr_in), .wdata(wdata),
  .rd_acc(rd_acc), .src_acc(src_acc), .wmp_acc(wmp_acc), .addr_q(addr_q),
  .rdata(rdata), .rvalid(rvalid), .port_out(port_out)
);

// File: tb/nibble_ram_tb_top.sv
module nibble_ram_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bank_en = 1'b1;
  logic       cmd_valid = 1'b0;
  logic [2:0] cmd = '0;
  logic [1:0] cmd_idx = '0;
  logic [7:0] addr_in = '0;
  logic [3:0] wdata = '0;
  logic [3:0] rdata;
  logic       rvalid;
  logic [3:0] port_out;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [3:0] mem_m  [64];
  logic [3:0] stat_m [16];
  logic [5:0] addr_m = '0;
  logic [3:0] port_m = '0;

  logic [3:0] exp_q [$];
  string      tag_q [$];

  always #10 clk = ~clk;

  nibble_ram dut_i (
    .clk(clk), .rst_n(rst_n), .bank_en(bank_en), .cmd_valid(cmd_valid),
    .cmd(cmd), .cmd_idx(cmd_idx), .addr_in(addr_in), .wdata(wdata),
    .rdata(rdata), .rvalid(rvalid), .port_out(port_out)
  );

  task automatic check4(input string tag, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic report();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  // Driver: one command per call, starting and ending at a falling edge.
  task automatic issue(input logic [2:0] op, input logic [1:0] idx, input logic [7:0] a,
                       input logic [3:0] d, input logic en, input string tag);
    cmd = op; cmd_idx = idx; addr_in = a; wdata = d; bank_en = en; cmd_valid = 1'b1;
    if (en) begin
      case (op)
        3'd1: addr_m = a[5:0];
        3'd2, 3'd7: begin exp_q.push_back(mem_m[addr_m]); tag_q.push_back(tag); end
        3'd3: mem_m[addr_m] = d;
        3'd4: begin exp_q.push_back(stat_m[{addr_m[5:4], idx}]); tag_q.push_back(tag); end
        3'd5: stat_m[{addr_m[5:4], idx}] = d;
        3'd6: port_m = d;
        default: ;
      endcase
    end
    @(posedge clk);
    @(negedge clk);
    cmd_valid = 1'b0; bank_en = 1'b1; cmd = '0;
  endtask

  // Monitor: compares every read result against the scoreboard queue.
  always @(negedge clk) begin
    if (rst_n) begin
      if (rvalid) begin
        if (exp_q.size() == 0) begin
          checks++; errors++;
          $display("FAIL R7 unexpected read result actual=%h expected=none", rdata);
        end else begin
          logic [3:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check4(t, rdata, e);
        end
      end else if (rdata !== 4'h0) begin
        check4("R9 rdata idle", rdata, 4'h0);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      report();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check4("R1 rdata after reset", rdata, 4'h0);
    check4("R1 rvalid after reset", {3'b0, rvalid}, 4'h0);
    check4("R1 port after reset", port_out, 4'h0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: held address is zero before any set-address command.
    issue(3'd3, 2'd0, 8'h00, 4'h9, 1'b1, "R1 write at reset address");
    // R2: upper two address bits ignored.
    issue(3'd1, 2'd0, 8'hC0, 4'h0, 1'b1, "R2 set address");
    issue(3'd2, 2'd0, 8'h00, 4'h0, 1'b1, "R1 read reset-address char");

    // R3: fill all main characters, then status.
    for (int i = 0; i < 64; i++) begin
      issue(3'd1, 2'd0, 8'(i), 4'h0, 1'b1, "R2 set address");
      issue(3'd3, 2'd0, 8'h00, 4'((i * 7 + 3) & 15), 1'b1, "R3 write char");
    end
    for (int r = 0; r < 4; r++) begin
      issue(3'd1, 2'd0, 8'(r * 16 + 5), 4'h0, 1'b1, "R2 set address");
      for (int k = 0; k < 4; k++)
        issue(3'd5, 2'(k), 8'h00, 4'((r * 4 + k) ^ 5), 1'b1, "R5 write status");
    end

    // R2/R3: read back with varied upper bits.
    for (int i = 0; i < 64; i++) begin
      issue(3'd1, 2'd0, 8'(i | ((i % 4) << 6)), 4'h0, 1'b1, "R2 set address");
      issue(3'd2, 2'd0, 8'h00, 4'h0, 1'b1, "R3 read char");
    end

    // R4: arithmetic operand read matches read-char.
    issue(3'd1, 2'd0, 8'h2B, 4'h0, 1'b1, "R2 set address");
    issue(3'd7, 2'd0, 8'h00, 4'h0, 1'b1, "R4 arithmetic read");
    issue(3'd2, 2'd0, 8'h00, 4'h0, 1'b1, "R4 plain read same char");

    // R5: status reads per register, and separation from main characters.
    for (int r = 0; r < 4; r++) begin
      issue(3'd1, 2'd0, 8'(r * 16 + 9), 4'h0, 1'b1, "R2 set address");
      for (int k = 0; k < 4; k++)
        issue(3'd4, 2'(k), 8'h00, 4'h0, 1'b1, "R5 read status");
    end
    issue(3'd1, 2'd0, 8'h21, 4'h0, 1'b1, "R2 set address");
    issue(3'd5, 2'd1, 8'h00, 4'hE, 1'b1, "R5 write status r2 i1");
    issue(3'd2, 2'd0, 8'h00, 4'h0, 1'b1, "R5 main char 1 untouched");
    issue(3'd4, 2'd1, 8'h00, 4'h0, 1'b1, "R5 read status r2 i1");

    // R6: port write, then other commands leave it alone.
    issue(3'd6, 2'd0, 8'h00, 4'hA, 1'b1, "R6 port write");
    check4("R6 port loaded", port_out, 4'hA);
    issue(3'd3, 2'd0, 8'h00, 4'h3, 1'b1, "R6 write char");
    issue(3'd5, 2'd2, 8'h00, 4'h6, 1'b1, "R6 write status");
    issue(3'd2, 2'd0, 8'h00, 4'h0, 1'b1, "R6 read char");
    check4("R6 port held", port_out, port_m);

    // R7: disabled commands have no effect.
    issue(3'd1, 2'd0, 8'h10, 4'h0, 1'b1, "R2 set address");
    issue(3'd3, 2'd0, 8'h00, 4'h0, 1'b1, "R7 enabled write");
    issue(3'd3, 2'd0, 8'h00, 4'hF, 1'b0, "R7 disabled write");
    issue(3'd5, 2'd0, 8'h00, 4'hF, 1'b0, "R7 disabled status write");
    issue(3'd1, 2'd0, 8'h3F, 4'h0, 1'b0, "R7 disabled set address");
    issue(3'd6, 2'd0, 8'h00, 4'h5, 1'b0, "R7 disabled port write");
    issue(3'd2, 2'd0, 8'h00, 4'h0, 1'b0, "R7 disabled read");
    check4("R7 rvalid after disabled read", {3'b0, rvalid}, 4'h0);
    check4("R7 port after disabled write", port_out, 4'hA);
    issue(3'd2, 2'd0, 8'h00, 4'h0, 1'b1, "R7 char unchanged, address kept");
    issue(3'd4, 2'd0, 8'h00, 4'h0, 1'b1, "R7 status unchanged");

    // R8: address held over many data commands, back-to-back reads.
    issue(3'd1, 2'd0, 8'h37, 4'h0, 1'b1, "R2 set address");
    for (int n = 0; n < 5; n++) begin
      issue(3'd3, 2'd0, 8'h00, 4'(n + 1), 1'b1, "R8 write same address");
      issue(3'd2, 2'd0, 8'h00, 4'h0, 1'b1, "R8 read same address");
      issue(3'd7, 2'd0, 8'h00, 4'h0, 1'b1, "R8 arithmetic read same address");
    end

    repeat (3) @(negedge clk);
    check4("R3 all results seen", 4'(exp_q.size()), 4'h0);
    done = 1;
    report();
    $finish;
  end
endmodule